// File: doc/BRIEF.md
# Key-Guarded Watchdog Reset Timer

This block is a watchdog counter with a reset output. Its control registers are guarded by a two-key unlock. A write bus of one cycle per access (enable, address, data) feeds both the unlock logic and the guarded registers.

To change a guarded register, software follows three steps:

1. It writes the first key to the first key address.
2. It writes the second key to the second key address.
3. It performs exactly one write to a guarded register.

Any other pattern of writes leaves the block locked, and a guarded write made while locked is dropped.

The guarded registers are the control register, the match value, the event status and the restart strobe. The control register runs the counter and arms the reset output. When the running counter reaches the match value, the counter halts there and a sticky event flag is raised. If the reset output is armed, a reset pulse of fixed length is driven. The system uses this block to force a chip reset after a programmed delay, or when software stops restarting the counter.

Top module: `wdk_reset_timer`

## Requirements
- R1: After reset `count_o`, `event_o` and `wdog_rst_o` are 0, the control bits are 0, the match value is all ones and the unlock logic is locked.
- R2: Writing 0xBABA to address 0x0 and then 0xEB10 to address 0x1 opens the lock, and the next write to a guarded address takes effect.
- R3: The lock closes again on the first write after it opens, so a second guarded write without a new key pair has no effect.
- R4: Any of the following returns the unlock logic to locked, and the guarded write after it has no effect: a key with the wrong value, the two keys in reverse order, or any other write between the two keys.
- R5: Guarded writes made while locked leave the control bits, the match value, the status and the counter unchanged.
- R6: The control register is at address 0x4. Bit 0 makes the counter advance by one every cycle, starting with the first edge after the write. Bit 1 arms the reset output. With bit 1 clear, no reset pulse is driven.
- R7: The match value is at address 0x3. When the running counter equals it, the counter holds that value and `event_o` rises one cycle later.
- R8: The status register is at address 0x2. A guarded write of 0 clears `event_o`. A guarded write of a nonzero value leaves it set.
- R9: The restart strobe is at address 0x5. A guarded write with any data sets the counter to 0 on that edge.
- R10: When the event flag rises with bit 1 set, `wdog_rst_o` goes high on that same edge for exactly RST_LEN cycles. A pulse that is already running is never lengthened or restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| count_o | output | CNT_W | Current counter value |
| event_o | output | 1 | Sticky watchdog event flag |
| wdog_rst_o | output | 1 | Reset pulse output |

## Verification
The hardest cases to reach are the rejected unlock sequences: a wrong key, keys in reverse order, a foreign write between the keys, and a second write after one accepted write. None of these drives an output directly. Each test therefore first leaves the counter running toward a distant match value and then issues a restart write after the faulty sequence, so that a counter still counting shows the write was refused. A correct full sequence followed by the same restart write confirms that the restart works when the lock is open. The pulse test clears and restarts everything under the lock and arms a short match. It then counts the high cycles and rising edges of the reset output over a window.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
   typedef enum logic [1:0] {LK_IDLE, LK_HALF, LK_OPEN} lock_e;

   localparam int unsigned ADR_KEY_A = 0;
   localparam int unsigned ADR_KEY_B = 1;
   localparam int unsigned ADR_STAT  = 2;
   localparam int unsigned ADR_MATCH = 3;
   localparam int unsigned ADR_CTRL  = 4;
   localparam int unsigned ADR_KICK  = 5;

   localparam int unsigned CTRL_W    = 2;
endpackage

// File: rtl/wdk_unlock.sv
module wdk_unlock
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A = 'hBABA,
   parameter logic [DATA_W-1:0] KEY_B = 'hEB10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              grant_o
);
   localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(ADR_KEY_A);
   localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(ADR_KEY_B);

   lock_e st_q, st_d;
   logic  key_a_hit, key_b_hit;

   assign key_a_hit = (wr_addr == A_KEY_A) && (wr_data == KEY_A);
   assign key_b_hit = (wr_addr == A_KEY_B) && (wr_data == KEY_B);

   always_comb begin
      st_d = st_q;
      if (wr_en) begin
         unique case (st_q)
            LK_IDLE: st_d = key_a_hit ? LK_HALF : LK_IDLE;
            LK_HALF: st_d = key_b_hit ? LK_OPEN : LK_IDLE;
            default: st_d = LK_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LK_IDLE;
      else        st_q <= st_d;
   end

   assign grant_o = wr_en && (st_q == LK_OPEN);
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
   parameter int unsigned CNT_W = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic             match_we,
   input  logic [CNT_W-1:0] match_d,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] match_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q, match_q;

   assign hit_o = run && (cnt_q == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (kick)           cnt_q <= '0;
      else if (run && !hit_o)  cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        match_q <= '1;
      else if (match_we) match_q <= match_d;
   end

   assign cnt_o   = cnt_q;
   assign match_o = match_q;
endmodule

// File: rtl/wdk_fire.sv
module wdk_fire #(
   parameter int unsigned RST_LEN = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic arm,
   input  logic clr,
   output logic event_o,
   output logic rst_o
);
   logic event_q, set, fire;

   assign set  = hit && !event_q;
   assign fire = set && arm && !rst_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   event_q <= 1'b0;
      else if (set) event_q <= 1'b1;
      else if (clr) event_q <= 1'b0;
   end
   assign event_o = event_q;

   generate
      if (RST_LEN == 1) begin : g_single
         logic rq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rq <= 1'b0;
            else        rq <= fire;
         end
         assign rst_o = rq;
      end else begin : g_stretch
         localparam int unsigned LW = $clog2(RST_LEN + 1);
         logic [LW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            left_q <= '0;
            else if (fire)         left_q <= LW'(RST_LEN);
            else if (left_q != '0) left_q <= left_q - 1'b1;
         end
         assign rst_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/wdk_reset_timer.sv
module wdk_reset_timer
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned RST_LEN = 8,
   parameter logic [DATA_W-1:0] KEY_A = 'hBABA,
   parameter logic [DATA_W-1:0] KEY_B = 'hEB10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic              event_o,
   output logic              wdog_rst_o
);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(ADR_MATCH);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(ADR_KICK);

   if (ADDR_W < 3)        begin : g_bad_addr  $error("ADDR_W must hold the address map"); end
   if (CNT_W > DATA_W)    begin : g_bad_cnt   $error("CNT_W may not exceed DATA_W"); end
   if (DATA_W < CTRL_W)   begin : g_bad_data  $error("DATA_W too narrow"); end
   if (RST_LEN < 1)       begin : g_bad_len   $error("RST_LEN must be at least 1"); end

   logic              grant;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  match_q;
   logic              hit, stat_clr, kick, match_we;

   wdk_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .grant_o(grant));

   assign stat_clr = grant && (wr_addr == A_STAT) && (wr_data == '0);
   assign kick     = grant && (wr_addr == A_KICK);
   assign match_we = grant && (wr_addr == A_MATCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           ctrl_q <= '0;
      else if (grant && wr_addr == A_CTRL)  ctrl_q <= wr_data[CTRL_W-1:0];
   end

   wdk_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .kick(kick),
      .match_we(match_we), .match_d(wr_data[CNT_W-1:0]),
      .cnt_o(count_o), .match_o(match_q), .hit_o(hit));

   wdk_fire #(.RST_LEN(RST_LEN)) u_fire (
      .clk(clk), .rst_n(rst_n), .hit(hit), .arm(ctrl_q[1]), .clr(stat_clr),
      .event_o(event_o), .rst_o(wdog_rst_o));
endmodule

// File: rtl/wdk_sva.sv
module wdk_sva
   import wdk_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned RST_LEN = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              grant,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [CNT_W-1:0]  match_q,
   input logic              hit,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              event_o,
   input logic              rst_o
);
   localparam int unsigned RW = $clog2(RST_LEN + 2);
   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_len <= '0;
      else if (rst_o) run_len <= run_len + 1'b1;
      else            run_len <= '0;
   end

   a_r3_lock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !grant);

   a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !grant |=> ($stable(ctrl_q) && $stable(match_q)));

   a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !(grant && wr_addr == ADDR_W'(ADR_KICK))) |=> $stable(cnt_o));

   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && wr_addr == ADDR_W'(ADR_STAT) && wr_data == '0 && !hit) |=> !event_o);

   a_r9_kick: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && wr_addr == ADDR_W'(ADR_KICK)) |=> (cnt_o == '0));

   a_r10_rst_with_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |-> (event_o && $past(ctrl_q[1])));

   a_r10_rst_len: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> (run_len < RW'(RST_LEN)));

   a_r4_wr_needed: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> wr_en);
endmodule

bind wdk_reset_timer wdk_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_sva (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .grant(grant), .ctrl_q(ctrl_q), .match_q(match_q), .hit(hit),
   .cnt_o(count_o), .event_o(event_o), .rst_o(wdog_rst_o));

// File: tb/tb_wdk_reset_timer.sv
module tb_wdk_reset_timer;
   localparam int AW = 4, DW = 32, CW = 32, RL = 8;
   localparam logic [AW-1:0] KA = 0, KB = 1, STAT = 2, MATCH = 3, CTRL = 4, KICK = 5;

   logic clk = 0, rst_n = 0, wr_en = 0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] count_o;
   logic event_o, wdog_rst_o;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdk_reset_timer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .RST_LEN(RL)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .count_o(count_o), .event_o(event_o), .wdog_rst_o(wdog_rst_o));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pwr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_wr(KA, 'hBABA);
      bus_wr(KB, 'hEB10);
      bus_wr(a, d);
   endtask

   task automatic t_reset();
      check(count_o == 0, "R1 count", count_o, 0);
      check(event_o == 0, "R1 event", event_o, 0);
      check(wdog_rst_o == 0, "R1 rst", wdog_rst_o, 0);
   endtask

   task automatic t_locked();
      bus_wr(CTRL, 3);
      bus_wr(MATCH, 0);
      repeat (5) @(negedge clk);
      check(count_o == 0, "R5 locked ctrl write ignored", count_o, 0);
      check(event_o == 0, "R5 locked match write ignored", event_o, 0);
   endtask

   task automatic t_run_match();
      pwr(MATCH, 5);
      pwr(CTRL, 1);
      check(count_o == 0, "R6 count at enable edge", count_o, 0);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k <= 5) check(count_o == k, "R6 increment", count_o, k);
         else        check(count_o == 5, "R7 hold at match", count_o, 5);
         check(event_o == (k >= 6), "R7 event timing", event_o, (k >= 6));
         check(wdog_rst_o == 0, "R6 no pulse when unarmed", wdog_rst_o, 0);
      end
   endtask

   task automatic t_clear();
      pwr(MATCH, 'h1000);
      pwr(STAT, 1);
      check(event_o == 1, "R8 nonzero write keeps event", event_o, 1);
      pwr(STAT, 0);
      check(event_o == 0, "R8 zero write clears event", event_o, 0);
   endtask

   task automatic t_kick();
      pwr(KICK, 'h77);
      check(count_o == 0, "R9 restart", count_o, 0);
      @(negedge clk);
      check(count_o == 1, "R9 counts after restart", count_o, 1);
   endtask

   task automatic t_single();
      bus_wr(KA, 'hBABA);
      bus_wr(KB, 'hEB10);
      bus_wr(MATCH, 'h2000);
      bus_wr(KICK, 0);
      check(count_o != 0, "R3 second write refused", count_o, 1);
   endtask

   task automatic t_badkeys();
      bus_wr(KA, 'hBABB); bus_wr(KB, 'hEB10); bus_wr(KICK, 0);
      check(count_o != 0, "R4 wrong key", count_o, 1);
      bus_wr(KB, 'hEB10); bus_wr(KA, 'hBABA); bus_wr(KICK, 0);
      check(count_o != 0, "R4 reverse order", count_o, 1);
      bus_wr(KA, 'hBABA); bus_wr(6, 0); bus_wr(KB, 'hEB10); bus_wr(KICK, 0);
      check(count_o != 0, "R4 write between keys", count_o, 1);
      pwr(KICK, 0);
      check(count_o == 0, "R2 full sequence opens", count_o, 0);
   endtask

   task automatic t_pulse();
      int highs = 0, rises = 0, first = -1;
      logic prev = 0;
      pwr(CTRL, 0);
      pwr(KICK, 0);
      pwr(STAT, 0);
      pwr(MATCH, 4);
      pwr(CTRL, 3);
      for (int k = 1; k <= 30; k++) begin
         @(negedge clk);
         if (wdog_rst_o) highs++;
         if (wdog_rst_o && !prev) begin rises++; if (first < 0) first = k; end
         prev = wdog_rst_o;
      end
      check(first == 5, "R10 pulse start", first, 5);
      check(highs == RL, "R10 pulse length", highs, RL);
      check(rises == 1, "R10 single pulse", rises, 1);
      check(event_o == 1, "R10 event set", event_o, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_run_match();
      t_clear();
      t_kick();
      t_single();
      t_badkeys();
      t_pulse();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule